// File: doc/BRIEF.md
# Asynchronous DRAM Controller with Refresh

This block sits between a simple synchronous request port and a conventional DRAM device whose address pins are shared between row and column. A request carries a flat address, a write flag and write data. The controller splits the address into its row field (upper bits) and column field (lower bits). It places the row on the pins and drops the row strobe, then places the column and drops the column strobe, with the write strobe low for writes. Every interval is counted in clock cycles and set by a parameter. After each column access the row stays open, so a following request to the same row needs only a new column cycle.

A free-running interval timer asks for one row refresh per period. The refresh is done by lowering the column strobe while the row strobe is high, so the device's internal counter supplies the row and the controller drives no row address for it. A pending refresh takes precedence over new user work. It closes the open page at the next access boundary and holds the request port not-ready until it has been served. An open page is also closed on its own before the row strobe has been low for longer than a parameterised limit.

Top module: `dram_async_ctrl`

## Requirements
- R1: After reset the row, column and write strobes are all high, `req_ready` is high and `rsp_valid` is low; whenever the controller is idle all three strobes stay high.
- R2: For each access, the row strobe falls with the row field (`req_addr[ROW_W+COL_W-1:COL_W]`) on `dram_addr[ROW_W-1:0]`. The column strobe later falls with the column field (`req_addr[COL_W-1:0]`) on `dram_addr[COL_W-1:0]`, at least `T_RCD` clock edges after the row strobe fell.
- R3: For a write the write strobe is already low when the column strobe falls and `dram_dq_out` holds the write data. For a read the write strobe stays high. The write strobe is never low while the row strobe is high.
- R4: Read data is sampled from `dram_dq_in` no earlier than `T_CAS` edges after the column strobe fell and no earlier than `T_RAC` edges after the row strobe fell. It is presented on `rsp_rdata` with a single-cycle `rsp_valid` pulse, with reads answered in request order.
- R5: Once the row strobe rises it stays high for at least `T_RP` clock cycles before it falls again.
- R6: A refresh cycle starts once per `REFI`-cycle timer period. No refresh starts later than the timer request by more than one access plus one precharge, even under continuous traffic.
- R7: A refresh lowers the column strobe while the row strobe is high, then lowers the row strobe, with the write strobe high throughout.
- R8: While a refresh is pending or in progress `req_ready` is low. A pending refresh is started before any further user row is opened.
- R9: A request to the row that is already open is served without a new fall of the row strobe.
- R10: A request to a different row closes the open row (row strobe high, precharge) and then opens the new row.
- R11: The row strobe is never held low for more than `T_RAS_MAX` clock cycles. An idle open page is closed on its own before that limit.
- R12: A read returns the data most recently written to the same address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request present |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Flat address, row field in the upper bits |
| req_wdata | input | DATA_W | Write data |
| req_ready | output | 1 | Request is taken on a clock edge where `req` and `req_ready` are both high |
| rsp_rdata | output | DATA_W | Read data |
| rsp_valid | output | 1 | One-cycle pulse marking `rsp_rdata` valid |
| dram_addr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_dq_out | output | DATA_W | Data to the device's data inputs |
| dram_dq_in | input | DATA_W | Data from the device's data outputs |

## Verification
The bench places a device model on the pins. The model drives inverted data whenever the row or column latency has not yet elapsed, so a controller that samples one cycle early returns corrupted reads rather than passing by luck. The model also checks that every strobe edge carries the address of the oldest request still outstanding, which catches swapped or mis-sliced row and column fields. Directed sequences count row-strobe falls across same-row and different-row requests, which exposes a page-hit path that reopens the row or a miss path that skips the precharge. An idle gap longer than the page timeout shows whether the open row is ever released. Random traffic with idle gaps keeps refresh competing with user requests, so a controller that starves refresh, raises ready during it or drives the write strobe in it is reported.

// File: rtl/dram_async_ctrl.sv
`timescale 1ns/1ps
module dram_async_ctrl #(
  parameter int ROW_W     = 10,
  parameter int COL_W     = 10,
  parameter int DATA_W    = 16,
  parameter int T_RCD     = 3,
  parameter int T_CAS     = 3,
  parameter int T_RAC     = 12,
  parameter int T_RP      = 8,
  parameter int T_RFC     = 10,
  parameter int REFI      = 3125,
  parameter int T_RAS_MAX = 2000
) (
  input  logic                                      clk,
  input  logic                                      rst_n,
  input  logic                                      req,
  input  logic                                      req_we,
  input  logic [ROW_W+COL_W-1:0]                    req_addr,
  input  logic [DATA_W-1:0]                         req_wdata,
  output logic                                      req_ready,
  output logic [DATA_W-1:0]                         rsp_rdata,
  output logic                                      rsp_valid,
  output logic [(ROW_W > COL_W ? ROW_W : COL_W)-1:0] dram_addr,
  output logic                                      dram_ras_n,
  output logic                                      dram_cas_n,
  output logic                                      dram_we_n,
  output logic [DATA_W-1:0]                         dram_dq_out,
  input  logic [DATA_W-1:0]                         dram_dq_in
);

  localparam int AW = ROW_W + COL_W;
  localparam int MW = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int CW = $clog2(REFI + T_RAS_MAX + 2) + 1;
  localparam logic [CW-1:0] RCD_M1   = CW'(T_RCD - 1);
  localparam logic [CW-1:0] CAS_M1   = CW'(T_CAS - 1);
  localparam logic [CW-1:0] RAC_M1   = CW'(T_RAC - 1);
  localparam logic [CW-1:0] RP_M1    = CW'(T_RP - 1);
  localparam logic [CW-1:0] RFC_M1   = CW'(T_RFC - 1);
  localparam logic [CW-1:0] REFI_M1  = CW'(REFI - 1);
  localparam logic [CW-1:0] RP_C     = CW'(T_RP);
  localparam logic [CW-1:0] RCD_C    = CW'(T_RCD);
  localparam logic [CW-1:0] RASMAX_C = CW'(T_RAS_MAX);
  localparam logic [CW-1:0] CLOSE_C  = CW'(T_RAS_MAX - T_CAS - 6);

  typedef enum logic [3:0] {
    S_IDLE, S_ACT, S_RCD, S_COLA, S_CASW, S_PAGE, S_PRE, S_RCBR, S_RREF
  } st_t;

  st_t               state;
  logic [CW-1:0]     cnt, ras_age, hi_age, ref_cnt;
  logic              ref_pend, pend;
  logic [ROW_W-1:0]  row_q;
  logic [COL_W-1:0]  col_q;
  logic              we_q;
  logic [DATA_W-1:0] wd_q;

  wire [ROW_W-1:0] in_row = req_addr[AW-1:COL_W];
  wire [COL_W-1:0] in_col = req_addr[COL_W-1:0];
  wire             ref_go = ref_pend && (state == S_IDLE || (state == S_PRE && cnt == '0));

  assign req_ready = !ref_pend &&
                     (state == S_IDLE || (state == S_PAGE && ras_age < CLOSE_C));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_cnt  <= '0;
      ref_pend <= 1'b0;
    end else begin
      ref_cnt <= (ref_cnt == REFI_M1) ? '0 : ref_cnt + 1'b1;
      if (ref_cnt == REFI_M1) ref_pend <= 1'b1;
      else if (ref_go)        ref_pend <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_age <= '0;
      hi_age  <= RP_C;
    end else if (dram_ras_n) begin
      ras_age <= '0;
      if (hi_age < RP_C) hi_age <= hi_age + 1'b1;
    end else begin
      ras_age <= ras_age + 1'b1;
      hi_age  <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      pend        <= 1'b0;
      row_q       <= '0;
      col_q       <= '0;
      we_q        <= 1'b0;
      wd_q        <= '0;
      dram_addr   <= '0;
      dram_ras_n  <= 1'b1;
      dram_cas_n  <= 1'b1;
      dram_we_n   <= 1'b1;
      dram_dq_out <= '0;
      rsp_rdata   <= '0;
      rsp_valid   <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (ref_pend) begin
            dram_cas_n <= 1'b0;
            state      <= S_RCBR;
          end else if (req) begin
            row_q     <= in_row;
            col_q     <= in_col;
            we_q      <= req_we;
            wd_q      <= req_wdata;
            dram_addr <= MW'(in_row);
            state     <= S_ACT;
          end
        end
        S_ACT: begin
          dram_ras_n <= 1'b0;
          cnt        <= RCD_M1;
          state      <= S_RCD;
        end
        S_RCD: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            dram_addr   <= MW'(col_q);
            dram_dq_out <= wd_q;
            dram_we_n   <= !we_q;
            state       <= S_COLA;
          end
        end
        S_COLA: begin
          dram_cas_n <= 1'b0;
          cnt        <= CAS_M1;
          state      <= S_CASW;
        end
        S_CASW: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (ras_age >= RAC_M1) begin
            dram_cas_n <= 1'b1;
            dram_we_n  <= 1'b1;
            if (!we_q) begin
              rsp_rdata <= dram_dq_in;
              rsp_valid <= 1'b1;
            end
            state <= S_PAGE;
          end
        end
        S_PAGE: begin
          if (ref_pend || ras_age >= CLOSE_C) begin
            dram_ras_n <= 1'b1;
            cnt        <= RP_M1;
            state      <= S_PRE;
          end else if (req) begin
            col_q <= in_col;
            we_q  <= req_we;
            wd_q  <= req_wdata;
            if (in_row == row_q) begin
              dram_addr   <= MW'(in_col);
              dram_dq_out <= req_wdata;
              dram_we_n   <= !req_we;
              state       <= S_COLA;
            end else begin
              row_q      <= in_row;
              pend       <= 1'b1;
              dram_ras_n <= 1'b1;
              cnt        <= RP_M1;
              state      <= S_PRE;
            end
          end
        end
        S_PRE: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else if (ref_pend) begin
            dram_cas_n <= 1'b0;
            state      <= S_RCBR;
          end else if (pend) begin
            pend      <= 1'b0;
            dram_addr <= MW'(row_q);
            state     <= S_ACT;
          end else begin
            state <= S_IDLE;
          end
        end
        S_RCBR: begin
          dram_ras_n <= 1'b0;
          cnt        <= RFC_M1;
          state      <= S_RREF;
        end
        S_RREF: begin
          if (cnt != '0) cnt <= cnt - 1'b1;
          else begin
            dram_ras_n <= 1'b1;
            dram_cas_n <= 1'b1;
            cnt        <= RP_M1;
            state      <= S_PRE;
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_IDLE_STROBES: assert property (@(posedge clk) disable iff (!rst_n)
    (state == S_IDLE) |-> (dram_ras_n && dram_cas_n && dram_we_n)); // R1
  AST_RCD_MET: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(dram_cas_n) && !dram_ras_n) |-> (ras_age >= RCD_C)); // R2
  AST_WE_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_we_n |-> !dram_ras_n); // R3
  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R4
  AST_PRECHARGE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(dram_ras_n) |-> (hi_age >= RP_C)); // R5
  AST_CBR_READY_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (!dram_cas_n && dram_ras_n) |-> !req_ready); // R8
  AST_RAS_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
    !dram_ras_n |-> (ras_age < RASMAX_C)); // R11

endmodule

// File: tb/test_dram_async_ctrl.sv
`timescale 1ns/1ps
module test_dram_async_ctrl;
  localparam int ROW_W = 6;
  localparam int COL_W = 5;
  localparam int DW    = 16;
  localparam int AW    = ROW_W + COL_W;
  localparam int MW    = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int T_RCD = 3;
  localparam int T_CAS = 2;
  localparam int T_RAC = 8;
  localparam int T_RP  = 3;
  localparam int T_RFC = 5;
  localparam int REFI  = 400;
  localparam int T_RAS_MAX = 60;
  localparam int REF_SLACK = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req = 1'b0, req_we = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, rsp_valid, dram_ras_n, dram_cas_n, dram_we_n;
  logic [DW-1:0] rsp_rdata, dram_dq_out;
  logic [DW-1:0] dram_dq_in = '0;
  logic [MW-1:0] dram_addr;

  always #2.5 clk = ~clk;

  dram_async_ctrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DW), .T_RCD(T_RCD), .T_CAS(T_CAS),
    .T_RAC(T_RAC), .T_RP(T_RP), .T_RFC(T_RFC), .REFI(REFI), .T_RAS_MAX(T_RAS_MAX)
  ) i_dram_async_ctrl (
    .clk(clk), .rst_n(rst_n), .req(req), .req_we(req_we), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .rsp_valid(rsp_valid), .dram_addr(dram_addr), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_dq_out(dram_dq_out),
    .dram_dq_in(dram_dq_in)
  );

  int checks = 0, errors = 0, cyc = 0;
  logic [DW-1:0] dmem [int];
  logic [DW-1:0] ref_mem [int];
  int            acc_addr[$];
  bit            acc_we[$];
  logic [DW-1:0] acc_wd[$];
  logic [DW-1:0] exp_rd[$];

  bit prev_ras = 1'b1, prev_cas = 1'b1, cbr_armed = 1'b0;
  int hi_run = 100, lo_run = 0, ras_fall_cyc = 0, cas_fall_cyc = 0;
  int ref_count = 0, last_ref = 0, normal_falls = 0, cur_key = 0;
  logic [ROW_W-1:0] row_l = '0;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected run end", cyc);
      finish_run();
    end
  end

  function automatic logic [DW-1:0] rd_ref(input int a);
    return ref_mem.exists(a) ? ref_mem[a] : '0;
  endfunction

  // device model and pin checks, sampled away from the active edge
  always @(negedge clk) begin
    if (rst_n) begin
      if (prev_ras && !dram_ras_n) begin
        if (!dram_cas_n) begin
          chk(dram_we_n == 1'b1, "R7 write strobe high in refresh", dram_we_n, 1);
          chk(cbr_armed, "R7 column strobe before row strobe", cbr_armed, 1);
          chk(req_ready == 1'b0, "R8 ready low during refresh", req_ready, 0);
          chk(((ref_count == 0) ? cyc : cyc - last_ref) <= REFI + REF_SLACK,
              "R6 refresh interval", (ref_count == 0) ? cyc : cyc - last_ref, REFI + REF_SLACK);
          last_ref = cyc;
          ref_count++;
        end else begin
          chk(hi_run >= T_RP, "R5 precharge time", hi_run, T_RP);
          row_l = dram_addr[ROW_W-1:0];
          ras_fall_cyc = cyc;
          normal_falls++;
        end
      end
      if (!prev_ras && dram_ras_n)
        chk(lo_run <= T_RAS_MAX, "R11 row strobe low time", lo_run, T_RAS_MAX);
      if (prev_cas && !dram_cas_n) begin
        if (dram_ras_n) begin
          cbr_armed = 1'b1;
          chk(dram_we_n == 1'b1, "R7 write strobe high at refresh start", dram_we_n, 1);
          chk(req_ready == 1'b0, "R8 ready low at refresh start", req_ready, 0);
        end else begin
          cas_fall_cyc = cyc;
          cur_key = (int'(row_l) << COL_W) | int'(dram_addr[COL_W-1:0]);
          chk(cyc - ras_fall_cyc >= T_RCD, "R2 row-to-column delay", cyc - ras_fall_cyc, T_RCD);
          if (acc_addr.size() == 0) chk(1'b0, "R2 column cycle without request", 1, 0);
          else begin
            int a;
            bit w;
            logic [DW-1:0] d;
            a = acc_addr.pop_front();
            w = acc_we.pop_front();
            d = acc_wd.pop_front();
            chk(cur_key == a, "R2 row/column address", cur_key, a);
            chk(dram_we_n == !w, "R3 write strobe at column fall", dram_we_n, !w);
            if (w) begin
              chk(dram_dq_out == d, "R3 write data", dram_dq_out, d);
              dmem[cur_key] = dram_dq_out;
            end
          end
        end
      end
      if (!prev_cas && dram_cas_n) cbr_armed = 1'b0;
      if (dram_ras_n) begin hi_run++; lo_run = 0; end
      else begin lo_run++; hi_run = 0; end
      if (!dram_ras_n && !dram_cas_n && dram_we_n) begin
        logic [DW-1:0] v;
        v = dmem.exists(cur_key) ? dmem[cur_key] : '0;
        if ((cyc + 1 - ras_fall_cyc >= T_RAC) && (cyc + 1 - cas_fall_cyc >= T_CAS))
          dram_dq_in = v;
        else
          dram_dq_in = ~v;
      end else begin
        dram_dq_in = 16'hDEAD;
      end
      prev_ras = dram_ras_n;
      prev_cas = dram_cas_n;
      if (rsp_valid) begin
        if (exp_rd.size() == 0) chk(1'b0, "R4 unexpected read response", 1, 0);
        else begin
          logic [DW-1:0] e;
          e = exp_rd.pop_front();
          chk(rsp_rdata == e, "R4 R12 read data", rsp_rdata, e);
        end
      end
    end
  end

  task automatic issue(input bit we, input int addr, input logic [DW-1:0] wd);
    @(negedge clk);
    req = 1'b1; req_we = we; req_addr = AW'(addr); req_wdata = wd;
    while (!req_ready) @(negedge clk);
    acc_addr.push_back(addr);
    acc_we.push_back(we);
    acc_wd.push_back(wd);
    if (we) ref_mem[addr] = wd;
    else exp_rd.push_back(rd_ref(addr));
    @(posedge clk);
    #1 req = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 400 && (exp_rd.size() != 0 || acc_addr.size() != 0); i++)
      @(negedge clk);
    repeat (3) @(negedge clk);
  endtask

  task automatic wait_refresh();
    int r0;
    r0 = ref_count;
    while (ref_count == r0) @(negedge clk);
  endtask

  function automatic int mk(input int row, input int col);
    return (row << COL_W) | col;
  endfunction

  initial begin
    int f0;
    void'($urandom(32'd20240611));
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(dram_ras_n == 1'b1, "R1 row strobe after reset", dram_ras_n, 1);
    chk(dram_cas_n == 1'b1, "R1 column strobe after reset", dram_cas_n, 1);
    chk(dram_we_n == 1'b1, "R1 write strobe after reset", dram_we_n, 1);
    chk(req_ready == 1'b1, "R1 ready after reset", req_ready, 1);
    chk(rsp_valid == 1'b0, "R1 valid after reset", rsp_valid, 0);

    // R9: same-row accesses keep the row open
    wait_refresh();
    f0 = normal_falls;
    issue(1'b1, mk(5, 1), 16'hA5C3);
    issue(1'b0, mk(5, 1), '0);
    issue(1'b1, mk(5, 2), 16'h1234);
    issue(1'b0, mk(5, 2), '0);
    drain();
    chk(normal_falls - f0 == 1, "R9 one row open for page hits", normal_falls - f0, 1);

    // R10: different row closes and reopens
    f0 = normal_falls;
    issue(1'b0, mk(9, 1), '0);
    issue(1'b0, mk(5, 1), '0);
    drain();
    chk(normal_falls - f0 == 2, "R10 row change reopens", normal_falls - f0, 2);

    // R11: idle open page is released
    issue(1'b1, mk(9, 31), 16'hBEEF);
    repeat (80) @(negedge clk);
    chk(dram_ras_n == 1'b1, "R11 idle page closed", dram_ras_n, 1);
    issue(1'b0, mk(9, 31), '0);
    issue(1'b0, mk(63, 0), '0);
    drain();

    // random traffic over a few rows, with idle gaps
    for (int n = 0; n < 300; n++) begin
      int row, col;
      row = (($urandom_range(0, 3) * 21) % 64);
      col = $urandom_range(0, 31);
      issue($urandom_range(0, 1) == 1, mk(row, col), DW'($urandom));
      if ($urandom_range(0, 9) == 0) repeat ($urandom_range(20, 70)) @(negedge clk);
    end
    drain();
    chk(exp_rd.size() == 0, "R12 all reads answered", exp_rd.size(), 0);
    chk(acc_addr.size() == 0, "R2 all accesses issued", acc_addr.size(), 0);
    chk(ref_count >= cyc / REFI - 1, "R6 refresh count", ref_count, cyc / REFI - 1);
    finish_run();
  end
endmodule